// File: doc/BRIEF.md
# Clock Source Mode Controller

This block is the decision logic of a microcontroller clock unit. It keeps the clock control and divider settings written by software. From them it produces select and enable signals for the PLL, its multiplier and post-divider, the system clock source, the CPU prescaler, the divide-by-2 stage and the crystal oscillator. The analog parts and the glitch-free clock switching sit outside the block. They are driven only through these outputs.

The block tracks wait-for-interrupt. With low power disabled, entering wait only gates the CPU clock. With low power enabled, the hardware itself rewrites the control bits. It turns the PLL off and moves the system clock to the crystal divided by 16. If software asked for the auxiliary low-frequency clock and that clock is reported present, the hardware selects the auxiliary clock instead and stops the crystal. A wake event restarts only the CPU clock. Returning to a fast clock is left to software.

The auxiliary clock can never be selected while the presence detector reports it absent. A selected auxiliary clock that disappears falls back to the divide-by-16 source. Each time the system clock moves into or out of the slow or auxiliary source, a maskable interrupt pulses low for one cycle. A restart after a hardware stop raises the same pulse.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset: `src_sel`=00 (crystal/2), `half_en`=1, `post_div`=8, `cpu_div`=1, `mult_factor`=10, `pll_on`=0, `xtal_on`=1, `cpu_clk_en`=1, `aux_active`=0, `irq_n`=1.
- R2: The divider register is written with `wr_sel`=1. In it, bits [1:0] pick the multiplier (10→14, 00→10, 11→8, 01→6), bits [4:2] hold D−1, so that `post_div`=D, and bits [7:5] hold N−1, so that `cpu_div`=N. All of these take effect the cycle after the write.
- R3: The control register is written with `wr_sel`=0 and has these bits: [0] low power in wait, [1] auxiliary clock in wait, [2] select auxiliary, [3] crystal stop, [4] interrupt enable, [5] full rate (0 selects the divide-by-16 source), [6] divide-by-2, [7] PLL select. When bit 0 is 0, a `wfi_enter` pulse drops `cpu_clk_en` the next cycle and leaves `src_sel`, `pll_on` and the dividers unchanged. A `wake` pulse sets `cpu_clk_en` again.
- R4: When bit 0 is 1, a `wfi_enter` pulse with no auxiliary clock in use clears PLL select and full rate. The next cycle then shows `src_sel`=10 (slow) and `pll_on`=0.
- R5: When bits 0 and 1 are both 1 and `aux_present` is 1, a `wfi_enter` pulse selects the auxiliary clock and sets crystal stop. The next cycle then shows `src_sel`=11, `aux_active`=1, `xtal_on`=0 and `pll_on`=0.
- R6: A control write with bit 2 set while `aux_present`=0 leaves `aux_active` and `src_sel` as they were. A write with bit 2 clear deselects the auxiliary clock.
- R7: `xtal_on` goes to 0 only while crystal stop is set and the auxiliary clock is active.
- R8: `irq_n` idles high. It is low for exactly one cycle, the cycle after `src_sel` enters or leaves the slow source or the auxiliary source, and only if interrupt enable is 1.
- R9: A `hw_restart` pulse drives `irq_n` low for the next cycle when interrupt enable is 1.
- R10: If `aux_present` is 0 while `aux_active` is 1, the next cycle shows `aux_active`=0 and `src_sel`=10, and the change raises the R8 interrupt.
- R11: `wake` does not change `src_sel` or `pll_on`. The clock source chosen on entering wait stays until software writes the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = divider register |
| wr_data | input | 8 | Write data |
| wfi_enter | input | 1 | CPU enters wait-for-interrupt (pulse) |
| wake | input | 1 | Interrupt wakes the CPU (pulse) |
| hw_restart | input | 1 | System clock restarted after a hardware stop (pulse) |
| aux_present | input | 1 | Auxiliary clock detected |
| src_sel | output | 2 | 00 crystal/2, 01 PLL, 10 crystal/16 slow, 11 auxiliary |
| pll_on | output | 1 | PLL enable |
| mult_factor | output | 4 | PLL multiplication factor |
| post_div | output | 4 | PLL post-divide ratio D |
| cpu_div | output | 4 | CPU prescale ratio N |
| half_en | output | 1 | Divide-by-2 stage enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| xtal_on | output | 1 | Crystal oscillator enable |
| aux_active | output | 1 | Auxiliary clock selected |
| irq_n | output | 1 | Active-low one-cycle interrupt |

## Verification
Wait entry is applied under three settings: low power off, low power on with the auxiliary clock absent, and low power on with the auxiliary clock present. Together these separate a pure CPU gate, the slow substitution and the auxiliary substitution. Selection writes are made with and without the detector. This shows that the ignore rule and the crystal-stop gate depend on presence and not on the write alone. Removing the auxiliary clock while it is in use, and repeating source switches and restart pulses with the interrupt masked and unmasked, separates real events from spurious pulses. A behavioural model is compared with every output on every cycle, so any wrong interrupt cycle is caught at once.

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       wfi_enter,
  input  logic       wake,
  input  logic       hw_restart,
  input  logic       aux_present,
  output logic [1:0] src_sel,
  output logic       pll_on,
  output logic [3:0] mult_factor,
  output logic [3:0] post_div,
  output logic [3:0] cpu_div,
  output logic       half_en,
  output logic       cpu_clk_en,
  output logic       xtal_on,
  output logic       aux_active,
  output logic       irq_n
);
  localparam logic [1:0] SRC_XT2  = 2'b00;
  localparam logic [1:0] SRC_PLL  = 2'b01;
  localparam logic [1:0] SRC_SLOW = 2'b10;
  localparam logic [1:0] SRC_AUX  = 2'b11;

  logic       lp_wfi_r, wfi_aux_r, aux_r, xstop_r, irq_en_r, full_r, half_r, pll_r;
  logic [1:0] mx_r;
  logic [2:0] dx_r, prs_r;
  logic       in_wfi_r;
  logic [1:0] src_prev_r;
  logic       irq_n_r;

  wire ctl_wr = wr_en && !wr_sel;
  wire div_wr = wr_en &&  wr_sel;
  wire lp_entry = wfi_enter && !in_wfi_r && lp_wfi_r;
  wire aux_lost = aux_r && !aux_present;
  wire slow_evt = (src_sel[1] != src_prev_r[1]) || (src_sel[0] != src_prev_r[0] && (src_sel[1] || src_prev_r[1]));

  assign src_sel = aux_r ? SRC_AUX : (!full_r ? SRC_SLOW : (pll_r ? SRC_PLL : SRC_XT2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_wfi_r  <= 1'b0;
      wfi_aux_r <= 1'b0;
      aux_r     <= 1'b0;
      xstop_r   <= 1'b0;
      irq_en_r  <= 1'b0;
      full_r    <= 1'b1;
      half_r    <= 1'b1;
      pll_r     <= 1'b0;
    end else if (aux_lost) begin
      aux_r  <= 1'b0;
      full_r <= 1'b0;
    end else if (lp_entry) begin
      pll_r <= 1'b0;
      if (wfi_aux_r && aux_present) begin
        aux_r   <= 1'b1;
        xstop_r <= 1'b1;
      end else if (!aux_r) begin
        full_r <= 1'b0;
      end
    end else if (ctl_wr) begin
      lp_wfi_r  <= wr_data[0];
      wfi_aux_r <= wr_data[1];
      if (!wr_data[2])      aux_r <= 1'b0;
      else if (aux_present) aux_r <= 1'b1;
      xstop_r   <= wr_data[3];
      irq_en_r  <= wr_data[4];
      full_r    <= wr_data[5];
      half_r    <= wr_data[6];
      pll_r     <= wr_data[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mx_r  <= 2'b00;
      dx_r  <= 3'b111;
      prs_r <= 3'b000;
    end else if (div_wr) begin
      mx_r  <= wr_data[1:0];
      dx_r  <= wr_data[4:2];
      prs_r <= wr_data[7:5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_wfi_r   <= 1'b0;
      src_prev_r <= SRC_XT2;
      irq_n_r    <= 1'b1;
    end else begin
      if (wake)           in_wfi_r <= 1'b0;
      else if (wfi_enter) in_wfi_r <= 1'b1;
      src_prev_r <= src_sel;
      irq_n_r    <= !(irq_en_r && (slow_evt || hw_restart));
    end
  end

  always_comb begin
    case (mx_r)
      2'b10:   mult_factor = 4'd14;
      2'b00:   mult_factor = 4'd10;
      2'b11:   mult_factor = 4'd8;
      default: mult_factor = 4'd6;
    endcase
  end

  assign post_div   = {1'b0, dx_r} + 4'd1;
  assign cpu_div    = {1'b0, prs_r} + 4'd1;
  assign half_en    = half_r;
  assign pll_on     = pll_r;
  assign cpu_clk_en = !in_wfi_r;
  assign xtal_on    = !(xstop_r && aux_r);
  assign aux_active = aux_r;
  assign irq_n      = irq_n_r;
endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic       wfi_enter,
  input logic       wake,
  input logic       aux_present,
  input logic       cpu_clk_en,
  input logic       pll_on,
  input logic       xtal_on,
  input logic       aux_active,
  input logic [1:0] src_sel,
  input logic       irq_n,
  input logic       lp_wfi_r,
  input logic       irq_en_r
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !irq_n |=> irq_n); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !irq_en_r |=> irq_n); // R8
  AST_WFI_GATES_CPU: assert property (@(posedge clk) disable iff (!rst_n) (wfi_enter && !wake) |=> !cpu_clk_en); // R3
  AST_LP_PLL_OFF: assert property (@(posedge clk) disable iff (!rst_n) (wfi_enter && cpu_clk_en && lp_wfi_r) |=> !pll_on); // R4
  AST_XTAL_STOP_GATED: assert property (@(posedge clk) disable iff (!rst_n) !xtal_on |-> aux_active); // R7
  AST_AUX_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[2] && !aux_present && !aux_active) |=> !aux_active); // R6
  AST_AUX_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_active && !aux_present) |=> (!aux_active && src_sel == 2'b10)); // R10
  AST_WAKE_KEEPS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !wr_en && !wfi_enter && aux_present) |=> $stable(src_sel)); // R11
endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .wfi_enter(wfi_enter), .wake(wake), .aux_present(aux_present),
  .cpu_clk_en(cpu_clk_en), .pll_on(pll_on), .xtal_on(xtal_on),
  .aux_active(aux_active), .src_sel(src_sel), .irq_n(irq_n),
  .lp_wfi_r(lp_wfi_r), .irq_en_r(irq_en_r)
);

// File: tb/clk_mode_ctrl_bench.sv
module clk_mode_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0, wfi_enter = 0, wake = 0, hw_restart = 0, aux_present = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] src_sel;
  logic pll_on, half_en, cpu_clk_en, xtal_on, aux_active, irq_n;
  logic [3:0] mult_factor, post_div, cpu_div;

  int checks = 0, errors = 0, irq_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clk_mode_ctrl u_clk_mode_ctrl (.*);

  // reference model state
  bit m_lp, m_wa, m_aux, m_xs, m_ie, m_full = 1, m_half = 1, m_pll, m_wfi, m_irq_n = 1;
  int m_mx = 0, m_d = 8, m_n = 1, m_prev = 0;

  function automatic int m_src();
    if (m_aux) return 3;
    if (!m_full) return 2;
    return m_pll ? 1 : 0;
  endfunction

  function automatic int mult_of(int code);
    case (code)
      2: return 14;
      0: return 10;
      3: return 8;
      default: return 6;
    endcase
  endfunction

  always @(posedge clk) begin
    int s;
    bit ev;
    if (!rst_n) begin
      m_lp = 0; m_wa = 0; m_aux = 0; m_xs = 0; m_ie = 0; m_full = 1; m_half = 1; m_pll = 0;
      m_wfi = 0; m_irq_n = 1; m_mx = 0; m_d = 8; m_n = 1; m_prev = 0;
    end else begin
      s = m_src();
      ev = ((s >= 2) != (m_prev >= 2)) || ((s == 3) != (m_prev == 3));
      m_irq_n = !(m_ie && (ev || hw_restart));
      m_prev = s;
      if (m_aux && !aux_present) begin
        m_aux = 0; m_full = 0;
      end else if (wfi_enter && !m_wfi && m_lp) begin
        m_pll = 0;
        if (m_wa && aux_present) begin m_aux = 1; m_xs = 1; end
        else if (!m_aux) m_full = 0;
      end else if (wr_en && !wr_sel) begin
        m_lp = wr_data[0]; m_wa = wr_data[1];
        if (!wr_data[2]) m_aux = 0; else if (aux_present) m_aux = 1;
        m_xs = wr_data[3]; m_ie = wr_data[4]; m_full = wr_data[5];
        m_half = wr_data[6]; m_pll = wr_data[7];
      end
      if (wr_en && wr_sel) begin
        m_mx = wr_data[1:0]; m_d = wr_data[4:2] + 1; m_n = wr_data[7:5] + 1;
      end
      if (wake) m_wfi = 0; else if (wfi_enter) m_wfi = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 src_sel", src_sel, m_src());
      chk("R4 pll_on", pll_on, m_pll);
      chk("R3 cpu_clk_en", cpu_clk_en, !m_wfi);
      chk("R7 xtal_on", xtal_on, !(m_xs && m_aux));
      chk("R6 aux_active", aux_active, m_aux);
      chk("R8 irq_n", irq_n, m_irq_n);
      chk("R2 mult_factor", mult_factor, mult_of(m_mx));
      chk("R2 post_div", post_div, m_d);
      chk("R2 cpu_div", cpu_div, m_n);
      chk("R1 half_en", half_en, m_half);
      if (!irq_n) irq_cnt++;
    end
  end

  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_wfi();
    @(negedge clk); wfi_enter = 1; @(negedge clk); wfi_enter = 0; repeat (3) @(negedge clk);
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1; @(negedge clk); wake = 0; repeat (3) @(negedge clk);
  endtask

  task automatic pulse_restart();
    @(negedge clk); hw_restart = 1; @(negedge clk); hw_restart = 0; repeat (3) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 src", src_sel, 0); chk("R1 post_div", post_div, 8); chk("R1 cpu_div", cpu_div, 1);
    chk("R1 half", half_en, 1); chk("R1 pll", pll_on, 0); chk("R1 irq_n", irq_n, 1);
    chk("R1 mult", mult_factor, 10); chk("R1 xtal", xtal_on, 1);

    wr(1, {3'b011, 3'b010, 2'b10});
    chk("R2 x14", mult_factor, 14); chk("R2 D", post_div, 3); chk("R2 N", cpu_div, 4);
    wr(1, 8'b000_000_01); chk("R2 x6", mult_factor, 6);
    wr(1, 8'b111_111_11); chk("R2 x8", mult_factor, 8); chk("R2 N8", cpu_div, 8);

    wr(0, 8'b1011_0000);
    chk("R3 pll src", src_sel, 1);
    pulse_wfi();
    chk("R3 cpu stopped", cpu_clk_en, 0); chk("R3 src kept", src_sel, 1); chk("R3 pll kept", pll_on, 1);
    pulse_wake();
    chk("R3 cpu back", cpu_clk_en, 1);

    base = irq_cnt;
    wr(0, 8'b1011_0100);
    chk("R6 aux ignored", aux_active, 0); chk("R6 src kept", src_sel, 1);
    wr(0, 8'b1011_1000);
    chk("R7 xtal kept", xtal_on, 1);
    chk("R8 no irq", irq_cnt - base, 0);

    wr(0, 8'b1011_0011);
    base = irq_cnt;
    pulse_wfi();
    chk("R4 slow", src_sel, 2); chk("R4 pll off", pll_on, 0);
    chk("R8 one pulse", irq_cnt - base, 1);
    pulse_wake();
    chk("R11 src kept", src_sel, 2);

    wr(0, 8'b1011_0011);
    chk("R11 sw restore", src_sel, 1);
    aux_present = 1;
    base = irq_cnt;
    pulse_wfi();
    chk("R5 aux", src_sel, 3); chk("R5 xtal off", xtal_on, 0); chk("R5 aux flag", aux_active, 1);
    chk("R8 pulse aux", irq_cnt - base, 1);
    pulse_wake();
    base = irq_cnt;
    @(negedge clk); aux_present = 0; repeat (3) @(negedge clk);
    chk("R10 fallback", src_sel, 2); chk("R10 flag", aux_active, 0);
    chk("R10 irq", irq_cnt - base, 1);

    base = irq_cnt;
    pulse_restart();
    chk("R9 restart irq", irq_cnt - base, 1);
    wr(0, 8'b0010_0000);
    base = irq_cnt;
    pulse_restart();
    aux_present = 1;
    wr(0, 8'b0010_0100);
    chk("R8 masked", irq_cnt - base, 0);
    chk("R6 direct aux", src_sel, 3);
    wr(0, 8'b0010_1100);
    chk("R7 xtal stop", xtal_on, 0);
    wr(0, 8'b0010_1000);
    chk("R7 deselect restarts xtal", xtal_on, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule